// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block drives the command, bank and address pins of a DDR SDRAM controller from reset until the memory is ready for normal traffic. It waits for a flag saying that supply and clock are stable, then holds the bus idle for a timed interval. After that it closes every bank and writes the extended mode register. Next it writes the base mode register with a one-shot DLL reset request. It then issues a programmable number of auto-refresh commands and waits a fixed settling period. Finally it raises a done flag and keeps the bus at NOP.

The base mode word comes from static configuration inputs: burst length, burst type and CAS latency. The extended mode word is taken whole from a configuration input. If the burst length or CAS latency code is a reserved value, the block raises an error flag and issues no command. All intervals are elaboration parameters. The idle hold is computed from the clock frequency in MHz and a duration in microseconds. The state machine moves through these states: WAIT_PWR, STABLE, PRECHARGE, TRP, EMRS, EMRS_WAIT, MRS, MRS_WAIT, REFRESH, RFC_WAIT, SETTLE, DONE and CFG_ERR.

The transitions are as follows:
- WAIT_PWR goes to CFG_ERR when the configuration is illegal, and to STABLE when the stable flag is high.
- STABLE falls back to WAIT_PWR if the flag drops, and goes to PRECHARGE when its count expires.
- Each command state moves to its wait state.
- Each wait state moves to the next command when its count expires.
- RFC_WAIT goes back to REFRESH until the refresh count is reached, then to SETTLE.
- SETTLE goes to DONE.
- DONE and CFG_ERR hold until reset.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, the block drives NOP ({cs_n,ras_n,cas_n,we_n} = 0111), bank and address zero, and `init_done` and `cfg_error` low.
- R2: The bus stays at NOP until `pwr_stable` has been high for STABLE_CYC = CLK_MHZ*STABLE_US consecutive cycles. The precharge appears on the next cycle.
- R3: If `pwr_stable` drops during the hold, the count restarts from the next rise.
- R4: The precharge-all command is 0010 with address bit 10 high, all other address bits zero, and bank zero.
- R5: The extended mode write (0000, bank = 01, address = `cfg_ext_mode`) comes T_RP cycles after the precharge. Every command lasts exactly one cycle.
- R6: The base mode write (0000, bank = 00) comes T_MRD cycles after the extended write. Its address carries burst length in bits 2..0, burst type in bit 3 and CAS latency in bits 6..4. Bit 8 (DLL reset) is 1 and all other bits are 0.
- R7: The first auto-refresh (0001) comes T_MRD cycles after the base mode write. REFRESH_COUNT refreshes are issued in total, spaced T_RFC cycles apart.
- R8: `init_done` rises T_RFC + SETTLE_CYC cycles after the last refresh. It then stays high with the bus at NOP until reset.
- R9: A burst length code other than 001, 010 or 011, or a CAS latency code other than 010 or 110, raises `cfg_error`. In that case no command other than NOP is issued and `init_done` stays low.
- R10: A reset in mid-sequence returns the bus to NOP with `init_done` low, and a complete sequence follows after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_stable | input | 1 | Supply and clock reported stable |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_burst_type | input | 1 | 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_ext_mode | input | ADDR_W | Extended mode register word |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row / mode address |
| init_done | output | 1 | Initialization finished |
| cfg_error | output | 1 | Reserved configuration code requested |

## Verification
The pins are registered from the next state, so a command shows on the first clock edge after its state is entered. The precharge appears STABLE_CYC+1 edges after `pwr_stable` is first sampled high. From then on, each later command is due exactly T_RP, T_MRD, T_MRD and then T_RFC cycles after the one before it, and `init_done` is due T_RFC+SETTLE_CYC after the last refresh. The bench counts falling edges from the cycle in which it raised `pwr_stable`. At every non-NOP cycle it compares that index with the expected index and the pin values with the expected word. An error flag is due one edge after reset release.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [3:0] {
        ST_WAIT_PWR,
        ST_STABLE,
        ST_PRECHARGE,
        ST_TRP,
        ST_EMRS,
        ST_EMRS_WAIT,
        ST_MRS,
        ST_MRS_WAIT,
        ST_REFRESH,
        ST_RFC_WAIT,
        ST_SETTLE,
        ST_DONE,
        ST_CFG_ERR
    } init_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_MRS = 4'b0000;
    localparam logic [3:0] CMD_REF = 4'b0001;

    localparam int PRE_ALL_BIT   = 10;
    localparam int DLL_RESET_BIT = 8;

    function automatic logic burst_code_legal(input logic [2:0] code);
        return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
    endfunction

    function automatic logic cas_code_legal(input logic [2:0] code);
        return (code == 3'b010) || (code == 3'b110);
    endfunction

endpackage

// File: rtl/ddr_wait_timer.sv
module ddr_wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr_mode_word.sv
module ddr_mode_word
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        burst_len,
    input  logic              burst_type,
    input  logic [2:0]        cas_lat,
    input  logic [ADDR_W-1:0] ext_mode,
    output logic [ADDR_W-1:0] base_word,
    output logic [ADDR_W-1:0] ext_word,
    output logic              cfg_ok
);

    always_comb begin
        base_word                = '0;
        base_word[2:0]           = burst_len;
        base_word[3]             = burst_type;
        base_word[6:4]           = cas_lat;
        base_word[DLL_RESET_BIT] = 1'b1;
    end

    assign ext_word = ext_mode;
    assign cfg_ok   = burst_code_legal(burst_len) && cas_code_legal(cas_lat);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int BA_W          = 2,
    parameter int CLK_MHZ       = 125,
    parameter int STABLE_US     = 200,
    parameter int T_RP          = 3,
    parameter int T_RFC         = 10,
    parameter int T_MRD         = 2,
    parameter int REFRESH_COUNT = 2,
    parameter int SETTLE_CYC    = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_stable,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_type,
    input  logic [2:0]        cfg_cas_lat,
    input  logic [ADDR_W-1:0] cfg_ext_mode,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done,
    output logic              cfg_error
);

    localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
    localparam int LONGEST    = (STABLE_CYC > SETTLE_CYC) ? STABLE_CYC : SETTLE_CYC;
    localparam int TW         = $clog2(LONGEST + 1);
    localparam int RW         = $clog2(REFRESH_COUNT + 1);

    localparam logic [TW-1:0] LD_STABLE = TW'(STABLE_CYC - 1);
    localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] LD_RP     = TW'(T_RP - 2);
    localparam logic [TW-1:0] LD_MRD    = TW'(T_MRD - 2);
    localparam logic [TW-1:0] LD_RFC    = TW'(T_RFC - 2);

    init_state_t       state_q, state_d;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_expired;
    logic [RW-1:0]     ref_q;
    logic              ref_inc;
    logic [ADDR_W-1:0] base_word;
    logic [ADDR_W-1:0] ext_word;
    logic              cfg_ok;

    ddr_mode_word #(
        .ADDR_W(ADDR_W)
    ) i_mode_word (
        .burst_len (cfg_burst_len),
        .burst_type(cfg_burst_type),
        .cas_lat   (cfg_cas_lat),
        .ext_mode  (cfg_ext_mode),
        .base_word (base_word),
        .ext_word  (ext_word),
        .cfg_ok    (cfg_ok)
    );

    ddr_wait_timer #(
        .W(TW)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    // Next-state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_inc  = 1'b0;
        unique case (state_q)
            ST_WAIT_PWR: begin
                if (!cfg_ok) begin
                    state_d = ST_CFG_ERR;
                end else if (pwr_stable) begin
                    state_d  = ST_STABLE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_STABLE;
                end
            end
            ST_STABLE: begin
                if (!pwr_stable) begin
                    state_d = ST_WAIT_PWR;
                end else if (tmr_expired) begin
                    state_d = ST_PRECHARGE;
                end
            end
            ST_PRECHARGE: begin
                state_d  = ST_TRP;
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
            end
            ST_TRP: begin
                if (tmr_expired) state_d = ST_EMRS;
            end
            ST_EMRS: begin
                state_d  = ST_EMRS_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_MRD;
            end
            ST_EMRS_WAIT: begin
                if (tmr_expired) state_d = ST_MRS;
            end
            ST_MRS: begin
                state_d  = ST_MRS_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_MRD;
            end
            ST_MRS_WAIT: begin
                if (tmr_expired) state_d = ST_REFRESH;
            end
            ST_REFRESH: begin
                state_d  = ST_RFC_WAIT;
                tmr_load = 1'b1;
                tmr_val  = LD_RFC;
                ref_inc  = 1'b1;
            end
            ST_RFC_WAIT: begin
                if (tmr_expired) begin
                    if (ref_q == RW'(REFRESH_COUNT)) begin
                        state_d  = ST_SETTLE;
                        tmr_load = 1'b1;
                        tmr_val  = LD_SETTLE;
                    end else begin
                        state_d = ST_REFRESH;
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) state_d = ST_DONE;
            end
            ST_DONE:    state_d = ST_DONE;
            ST_CFG_ERR: state_d = ST_CFG_ERR;
            default:    state_d = ST_WAIT_PWR;
        endcase
    end

    // State register and refresh counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_PWR;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            if (ref_inc) ref_q <= ref_q + 1'b1;
        end
    end

    // Registered pin decode from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
            ba        <= '0;
            addr      <= '0;
            init_done <= 1'b0;
            cfg_error <= 1'b0;
        end else begin
            {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
            ba        <= '0;
            addr      <= '0;
            init_done <= 1'b0;
            cfg_error <= 1'b0;
            unique case (state_d)
                ST_PRECHARGE: begin
                    {cs_n, ras_n, cas_n, we_n} <= CMD_PRE;
                    addr[PRE_ALL_BIT]          <= 1'b1;
                end
                ST_EMRS: begin
                    {cs_n, ras_n, cas_n, we_n} <= CMD_MRS;
                    ba   <= BA_W'(1);
                    addr <= ext_word;
                end
                ST_MRS: begin
                    {cs_n, ras_n, cas_n, we_n} <= CMD_MRS;
                    addr <= base_word;
                end
                ST_REFRESH: begin
                    {cs_n, ras_n, cas_n, we_n} <= CMD_REF;
                end
                ST_DONE:    init_done <= 1'b1;
                ST_CFG_ERR: cfg_error <= 1'b1;
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done,
    input logic              cfg_error
);

    logic [3:0] cmd;
    assign cmd = {cs_n, ras_n, cas_n, we_n};

    assert_pre_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> addr[10]);

    assert_single_cycle_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 4'b0111) |=> (cmd == 4'b0111));

    assert_dll_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000 && ba == '0) |-> (addr[8] && !addr[7]));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == 4'b0111));

    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |-> (cmd == 4'b0111 && !init_done));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ba       (ba),
    .addr     (addr),
    .init_done(init_done),
    .cfg_error(cfg_error)
);

// File: tb/test_ddr_init_seq.sv
`timescale 1ns/1ps
module test_ddr_init_seq;

    localparam int ADDR_W     = 13;
    localparam int BA_W       = 2;
    localparam int CLK_MHZ    = 125;
    localparam int STABLE_US  = 2;
    localparam int T_RP       = 3;
    localparam int T_RFC      = 8;
    localparam int T_MRD      = 2;
    localparam int REF_N      = 3;
    localparam int SETTLE_CYC = 200;
    localparam int STABLE_CYC = CLK_MHZ * STABLE_US;

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] MRS = 4'b0000;
    localparam logic [3:0] REF = 4'b0001;

    typedef struct packed {
        logic [2:0]        bl;
        logic              bt;
        logic [2:0]        cl;
        logic [ADDR_W-1:0] ext;
        logic              bad;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'b001, 1'b0, 3'b010, 13'h0000, 1'b0},
        '{3'b010, 1'b1, 3'b110, 13'h0002, 1'b0},
        '{3'b011, 1'b0, 3'b110, 13'h0001, 1'b0},
        '{3'b011, 1'b1, 3'b010, 13'h0000, 1'b0},
        '{3'b100, 1'b0, 3'b010, 13'h0000, 1'b1},
        '{3'b010, 1'b0, 3'b011, 13'h0000, 1'b1},
        '{3'b000, 1'b1, 3'b110, 13'h0000, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwr_stable = 1'b0;
    logic [2:0]        cfg_burst_len = 3'b001;
    logic              cfg_burst_type = 1'b0;
    logic [2:0]        cfg_cas_lat = 3'b010;
    logic [ADDR_W-1:0] cfg_ext_mode = '0;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic              init_done, cfg_error;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ddr_init_seq #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US),
        .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .REFRESH_COUNT(REF_N),
        .SETTLE_CYC(SETTLE_CYC)
    ) i_ddr_init_seq (
        .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable),
        .cfg_burst_len(cfg_burst_len), .cfg_burst_type(cfg_burst_type),
        .cfg_cas_lat(cfg_cas_lat), .cfg_ext_mode(cfg_ext_mode),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done), .cfg_error(cfg_error)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pins();
        return {13'd0, cs_n, ras_n, cas_n, we_n, ba, addr};
    endfunction

    function automatic logic [31:0] pack_pins(input logic [3:0] c, input logic [1:0] b,
                                              input logic [12:0] a);
        return {13'd0, c, b, a};
    endfunction

    task automatic apply_reset(input vec_t v);
        @(negedge clk);
        rst_n = 1'b0;
        pwr_stable = 1'b0;
        cfg_burst_len = v.bl;
        cfg_burst_type = v.bt;
        cfg_cas_lat = v.cl;
        cfg_ext_mode = v.ext;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Raise pwr_stable and follow a full legal sequence (R2, R4..R8)
    task automatic run_seq(input vec_t v);
        logic [12:0] mw;
        logic [3:0]  c;
        int          nxt;
        int          idx;
        bit          seen_done;
        mw = '0;
        mw[2:0] = v.bl;
        mw[3] = v.bt;
        mw[6:4] = v.cl;
        mw[8] = 1'b1;
        pwr_stable = 1'b1;
        idx = 0;
        nxt = STABLE_CYC + 1;
        seen_done = 1'b0;
        for (int k = 1; k <= 3000 && !seen_done; k++) begin
            @(negedge clk);
            c = {cs_n, ras_n, cas_n, we_n};
            if (init_done) begin
                check(k == nxt && idx == REF_N + 3, "R8", "done cycle", k, nxt);
                seen_done = 1'b1;
            end else if (c != NOP) begin
                if (idx == 0) begin
                    check(k == nxt, "R2", "precharge cycle", k, nxt);
                    check(pins() == pack_pins(PRE, 2'b00, 13'h0400), "R4", "precharge pins",
                          pins(), pack_pins(PRE, 2'b00, 13'h0400));
                    nxt = k + T_RP;
                end else if (idx == 1) begin
                    check(k == nxt, "R5", "ext mode cycle", k, nxt);
                    check(pins() == pack_pins(MRS, 2'b01, v.ext), "R5", "ext mode pins",
                          pins(), pack_pins(MRS, 2'b01, v.ext));
                    nxt = k + T_MRD;
                end else if (idx == 2) begin
                    check(k == nxt, "R6", "mode cycle", k, nxt);
                    check(pins() == pack_pins(MRS, 2'b00, mw), "R6", "mode pins",
                          pins(), pack_pins(MRS, 2'b00, mw));
                    nxt = k + T_MRD;
                end else begin
                    check(k == nxt && idx < REF_N + 3, "R7", "refresh cycle", k, nxt);
                    check(pins() == pack_pins(REF, 2'b00, 13'h0), "R7", "refresh pins",
                          pins(), pack_pins(REF, 2'b00, 13'h0));
                    nxt = (idx == REF_N + 2) ? k + T_RFC + SETTLE_CYC : k + T_RFC;
                end
                idx++;
            end
        end
        check(seen_done, "R8", "done reached", {31'd0, seen_done}, 32'd1);
        repeat (10) @(negedge clk);
        check(init_done && {cs_n, ras_n, cas_n, we_n} == NOP && !cfg_error, "R8",
              "done held quiet", {27'd0, init_done, cs_n, ras_n, cas_n, we_n}, 32'h17);
    endtask

    initial begin
        vec_t v;
        // R1: outputs while reset is held
        repeat (2) @(negedge clk);
        check(pins() == pack_pins(NOP, 2'b00, 13'h0) && !init_done && !cfg_error, "R1",
              "reset state", pins(), pack_pins(NOP, 2'b00, 13'h0));

        // Table walk
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            apply_reset(v);
            if (!v.bad) begin
                run_seq(v);
            end else begin
                bit quiet;
                @(negedge clk);
                check(cfg_error == 1'b1 && !init_done, "R9", "error flag",
                      {30'd0, cfg_error, init_done}, 32'h2);
                pwr_stable = 1'b1;
                quiet = 1'b1;
                for (int k = 0; k < STABLE_CYC + 40; k++) begin
                    @(negedge clk);
                    if ({cs_n, ras_n, cas_n, we_n} != NOP || init_done) quiet = 1'b0;
                end
                check(quiet && cfg_error, "R9", "no command issued",
                      {31'd0, quiet}, 32'd1);
            end
        end

        // R3: stable flag drops during the hold
        v = VECS[1];
        apply_reset(v);
        pwr_stable = 1'b1;
        repeat (100) @(negedge clk);
        pwr_stable = 1'b0;
        @(negedge clk);
        check({cs_n, ras_n, cas_n, we_n} == NOP, "R3", "nop during drop",
              {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, NOP});
        run_seq(v);

        // R10: reset in mid-sequence, then a full run
        v = VECS[2];
        apply_reset(v);
        pwr_stable = 1'b1;
        repeat (STABLE_CYC + 1 + T_RP) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check({cs_n, ras_n, cas_n, we_n} == NOP && !init_done && ba == '0 && addr == '0,
              "R10", "reset mid-sequence", pins(), pack_pins(NOP, 2'b00, 13'h0));
        pwr_stable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_seq(v);

        // R10/R1: reset after done clears the flag
        rst_n = 1'b0;
        #1;
        check(!init_done && !cfg_error, "R1", "reset clears done",
              {30'd0, init_done, cfg_error}, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule